// File: doc/BRIEF.md
# Blocking-Driven Core Speed Governor

This block sits beside one compute tile and selects the tile's operating point. Data enters and leaves the core through single-entry buffers. Each buffer raises a one-cycle pulse whenever a transfer is refused. A refused read on the input side means the core drains its input too slowly. A refused write on the output side means the core produces faster than the network accepts.

The governor counts both kinds of pulse over an observation window whose length is programmable. At the end of each window it makes one decision: move one step faster, move one step slower, or stay. There are four operating points: the clock divided by 1, 2, 4 and 8, each paired with its own supply code.

A step is applied in two halves separated by a programmable settle interval, so the supply never falls below what the current clock needs. When speeding up, the supply code moves first. When slowing down, the clock moves first.

Top module: `tile_speed_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `clk_div_sel` is 0 (divide by 1) and `volt_sel` is 3 (highest supply code).
- R2: Blocked pulses are counted over windows of `win_len` consecutive cycles (0 acts as 1). Windows follow one another back to back from the first cycle after reset. The first output change of an accepted step is registered on the clock edge after the edge that closes the window.
- R3: If (input-blocked count minus output-blocked count) is strictly greater than `threshold`, the operating point moves one step faster (`clk_div_sel` minus 1).
- R4: If that difference is strictly below minus `threshold`, the operating point moves one step slower (`clk_div_sel` plus 1).
- R5: A difference within plus or minus `threshold`, equality included, leaves both outputs unchanged.
- R6: A faster request at `clk_div_sel` 0, or a slower request at `clk_div_sel` 3, leaves both outputs unchanged.
- R7: On a faster step, `volt_sel` rises by one first. `clk_div_sel` then falls by one `settle_len`+1 cycles later.
- R8: On a slower step, `clk_div_sel` rises by one first. `volt_sel` then falls by one `settle_len`+1 cycles later.
- R9: `volt_sel` + `clk_div_sel` is never below 3, and the two outputs never change in the same cycle. Once settled, `volt_sel` equals 3 minus `clk_div_sel`.
- R10: A window decision that arrives while the second half of a step is still pending is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| in_blocked | input | 1 | One-cycle pulse: input buffer refused a read |
| out_blocked | input | 1 | One-cycle pulse: output buffer refused a write |
| win_len | input | WIN_W | Observation window length in cycles |
| threshold | input | WIN_W | Decision margin on the count difference |
| settle_len | input | SET_W | Extra wait between the two halves of a step |
| clk_div_sel | output | 2 | Clock divide exponent, divide by 2^value |
| volt_sel | output | 2 | Supply level code, 3 highest |

## Verification
The embedded properties assume that `win_len` and `settle_len` change only at a window boundary, and that each blocked input is a level sampled once per cycle. The stimulus writes the window length only in the cycle right after a window closes. It leaves the settle length fixed and drives the pulses at the falling edge. Some windows carry both pulse kinds in the same cycles. One shortened window lands exactly on the edge where a pending step completes, which exercises the discard rule.

// File: rtl/speed_pkg.sv
`timescale 1ns/1ps
package speed_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_FAST = 2'd0;
    localparam lvl_t LVL_SLOW = 2'd3;

    typedef enum logic [1:0] {DEC_HOLD, DEC_UP, DEC_DOWN} dec_e;
    typedef enum logic {SQ_IDLE, SQ_SETTLE} seq_e;

    typedef struct packed {
        lvl_t clk_div;
        lvl_t volt;
    } opoint_t;

    function automatic lvl_t volt_for(lvl_t l);
        return lvl_t'(LVL_SLOW - l);
    endfunction

    function automatic opoint_t op_for(lvl_t l);
        opoint_t o;
        o.clk_div = l;
        o.volt    = volt_for(l);
        return o;
    endfunction
endpackage

// File: rtl/blk_window.sv
`timescale 1ns/1ps
module blk_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_blk,
    input  logic             out_blk,
    input  logic [WIN_W-1:0] win_len,
    output logic             done,
    output logic [WIN_W-1:0] tot_in,
    output logic [WIN_W-1:0] tot_out
);
    logic [WIN_W-1:0] wcnt, acc_in, acc_out;
    logic [WIN_W:0]   wnext;
    logic             last;

    assign wnext = {1'b0, wcnt} + (WIN_W+1)'(1);
    assign last  = wnext >= {1'b0, win_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt    <= '0;
            acc_in  <= '0;
            acc_out <= '0;
            tot_in  <= '0;
            tot_out <= '0;
            done    <= 1'b0;
        end else if (last) begin
            tot_in  <= acc_in + WIN_W'(in_blk);
            tot_out <= acc_out + WIN_W'(out_blk);
            acc_in  <= '0;
            acc_out <= '0;
            wcnt    <= '0;
            done    <= 1'b1;
        end else begin
            acc_in  <= acc_in + WIN_W'(in_blk);
            acc_out <= acc_out + WIN_W'(out_blk);
            wcnt    <= wcnt + WIN_W'(1);
            done    <= 1'b0;
        end
    end

    // R2: a window longer than one cycle never closes on consecutive edges
    a_r2_done_spacing: assert property (@(posedge clk) disable iff (rst)
        (done && win_len > WIN_W'(1)) |=> !done);
endmodule

// File: rtl/blk_decide.sv
`timescale 1ns/1ps
module blk_decide
    import speed_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic [WIN_W-1:0] tot_in,
    input  logic [WIN_W-1:0] tot_out,
    input  logic [WIN_W-1:0] threshold,
    output dec_e             dec
);
    logic signed [WIN_W+1:0] diff, thr_s;

    always_comb begin
        diff  = $signed({2'b00, tot_in}) - $signed({2'b00, tot_out});
        thr_s = $signed({2'b00, threshold});
        if (diff > thr_s)       dec = DEC_UP;
        else if (diff < -thr_s) dec = DEC_DOWN;
        else                    dec = DEC_HOLD;
    end
endmodule

// File: rtl/step_sequencer.sv
`timescale 1ns/1ps
module step_sequencer
    import speed_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  dec_e             dec,
    input  logic [SET_W-1:0] settle_len,
    output lvl_t             clk_div_sel,
    output lvl_t             volt_sel
);
    seq_e             state;
    lvl_t             lvl;
    logic [SET_W-1:0] cnt;
    opoint_t          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            lvl   <= LVL_FAST;
            cnt   <= '0;
            out_q <= op_for(LVL_FAST);
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (valid && dec == DEC_UP && lvl != LVL_FAST) begin
                        lvl        <= lvl_t'(lvl - 2'd1);
                        out_q.volt <= volt_for(lvl_t'(lvl - 2'd1));
                        cnt        <= settle_len;
                        state      <= SQ_SETTLE;
                    end else if (valid && dec == DEC_DOWN && lvl != LVL_SLOW) begin
                        lvl           <= lvl_t'(lvl + 2'd1);
                        out_q.clk_div <= lvl_t'(lvl + 2'd1);
                        cnt           <= settle_len;
                        state         <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (cnt == '0) begin
                        out_q <= op_for(lvl);
                        state <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - SET_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign clk_div_sel = out_q.clk_div;
    assign volt_sel    = out_q.volt;

    a_r1_reset_point: assert property (@(posedge clk)
        rst |=> (clk_div_sel == LVL_FAST && volt_sel == LVL_SLOW));

    a_r9_supply_covers_clock: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, volt_sel} + {1'b0, clk_div_sel}) >= 3'd3);

    a_r9_one_output_moves: assert property (@(posedge clk) disable iff (rst)
        $stable(clk_div_sel) || $stable(volt_sel));

    a_r9_settled_pair: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE) |-> (volt_sel == volt_for(clk_div_sel)));

    a_r10_busy_discard: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SETTLE && valid) |=> $stable(lvl));
endmodule

// File: rtl/tile_speed_ctrl.sv
`timescale 1ns/1ps
module tile_speed_ctrl
    import speed_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_blocked,
    input  logic             out_blocked,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W-1:0] threshold,
    input  logic [SET_W-1:0] settle_len,
    output logic [1:0]       clk_div_sel,
    output logic [1:0]       volt_sel
);
    logic             win_done;
    logic [WIN_W-1:0] tot_in, tot_out;
    dec_e             dec;
    lvl_t             csel, vsel;

    blk_window #(.WIN_W(WIN_W)) u_window (
        .clk(clk), .rst(rst), .in_blk(in_blocked), .out_blk(out_blocked),
        .win_len(win_len), .done(win_done), .tot_in(tot_in), .tot_out(tot_out)
    );

    blk_decide #(.WIN_W(WIN_W)) u_decide (
        .tot_in(tot_in), .tot_out(tot_out), .threshold(threshold), .dec(dec)
    );

    step_sequencer #(.SET_W(SET_W)) u_seq (
        .clk(clk), .rst(rst), .valid(win_done), .dec(dec),
        .settle_len(settle_len), .clk_div_sel(csel), .volt_sel(vsel)
    );

    assign clk_div_sel = csel;
    assign volt_sel    = vsel;
endmodule

// File: tb/tile_speed_ctrl_bench.sv
`timescale 1ns/1ps
module tile_speed_ctrl_bench;
    logic       clk = 1'b0, rst = 1'b1, inb = 1'b0, outb = 1'b0;
    logic [7:0] wl = 8'd8, th = 8'd2;
    logic [3:0] st = 4'd3;
    logic [1:0] csel, vsel;

    tile_speed_ctrl u_tile_speed_ctrl (
        .clk(clk), .rst(rst), .in_blocked(inb), .out_blocked(outb),
        .win_len(wl), .threshold(th), .settle_len(st),
        .clk_div_sel(csel), .volt_sel(vsel)
    );

    always #10 clk = ~clk;

    int cyc;
    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    typedef struct {
        int    stamp;
        int    c;
        int    v;
        string req;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    int lvl = 0, wstart = 0, pend_end = -1;
    int pc = 0, pv = 3;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: every output change must match the head of the queue
    always @(negedge clk) begin
        if (rst) begin
            pc = csel; pv = vsel;
        end else if (int'(csel) != pc || int'(vsel) != pv) begin
            if (q.size() == 0) begin
                check("R5/R6", "unexpected output change", int'(csel)*4 + int'(vsel), pc*4 + pv);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.req, "change cycle (R2)", cyc, e.stamp);
                check(e.req, "clk_div_sel", int'(csel), e.c);
                check(e.req, "volt_sel", int'(vsel), e.v);
            end
            pc = csel; pv = vsel;
        end
    end

    task automatic run_window(int n_in, int n_out, int len);
        int e, d;
        wl = 8'(len);
        for (int i = 0; i < len; i++) begin
            inb  = (i < n_in);
            outb = (i < n_out);
            @(negedge clk);
        end
        inb = 1'b0; outb = 1'b0;
        if (wstart + len - 1 >= pend_end) begin
            check("R5/R6", "settled clk_div_sel", int'(csel), lvl);
            check("R9", "settled volt_sel", int'(vsel), 3 - lvl);
        end
        e = wstart + len;
        d = n_in - n_out;
        if (e > pend_end) begin
            if (d > int'(th) && lvl > 0) begin
                lvl--;
                q.push_back('{e + 1, lvl + 1, 3 - lvl, "R3/R7"});
                q.push_back('{e + 2 + int'(st), lvl, 3 - lvl, "R3/R7"});
                pend_end = e + 1 + int'(st);
            end else if (d < -int'(th) && lvl < 3) begin
                lvl++;
                q.push_back('{e + 1, lvl, 4 - lvl, "R4/R8"});
                q.push_back('{e + 2 + int'(st), lvl, 3 - lvl, "R4/R8"});
                pend_end = e + 1 + int'(st);
            end
        end
        wstart += len;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset clk_div_sel", int'(csel), 0);
        check("R1", "reset volt_sel", int'(vsel), 3);
        rst = 1'b0;
        run_window(3, 0, 8);  // R6 faster request at fastest point
        run_window(0, 3, 8);  // R4 R8 one step slower
        run_window(0, 2, 8);  // R5 equality holds
        run_window(0, 5, 8);  // R4
        run_window(1, 4, 8);  // R4 mixed pulses
        run_window(0, 8, 8);  // R6 slower request at slowest point
        run_window(2, 0, 8);  // R5
        run_window(3, 0, 8);  // R3 R7 faster
        run_window(5, 5, 8);  // R5 balanced
        run_window(4, 0, 4);  // R2 shorter window, R3
        run_window(4, 0, 4);  // R10 lands while step pending: discarded
        run_window(4, 0, 4);  // R3 to fastest
        run_window(0, 4, 4);  // R4
        run_window(0, 0, 8);
        run_window(0, 0, 8);
        check("R7/R8", "pending expected changes", q.size(), 0);
        finish_run();
    end
endmodule